// File: doc/BRIEF.md
# Oscillator Frequency Trim Controller

The block closes a trim loop around a fast on-chip oscillator. It runs entirely on the fast clock, watches a slow, accurate clock, and derives from it a reference tick at every 2^DIV_LOG2-th rising edge of the slow clock (512 by default). Between two consecutive ticks it counts fast-clock cycles. It compares that count with a programmed window and moves a trim code one step toward the window. The trim code drives the analog tuning input of the oscillator.

Software, or a power-management sequencer, sets the window bounds, raises the run input with the mode input at 0, and lets the loop run. The loop repeats measure-and-correct on every reference period until it is stopped. Whenever a measured period lands inside the window, the trim code is kept. If interrupts are enabled, a one-cycle pulse then reports that the oscillator is on target.

Top module: `osc_trim_ctrl`

## Requirements
- R1: The loop is active only while `run_en` is 1 and `mode_sel` is 0. When `run_en` is 0 or `mode_sel` is 1, the trim code keeps its value and `done_irq` stays 0.
- R2: The slow clock passes through a two-flop synchronizer. A reference tick occurs on every 2^DIV_LOG2-th synchronized rising edge of the slow clock, counted from reset. Other slow edges never change the trim code.
- R3: The first reference tick after the loop becomes active only starts a measurement. Every later tick ends one measurement and, in the same cycle, starts the next one (continuous operation).
- R4: The measured count is the number of fast cycles between two consecutive reference ticks. A count above `win_hi` lowers the trim code by 1. A count below `win_lo` raises it by 1.
- R5: A count with `win_lo` <= count <= `win_hi` (both bounds included) leaves the trim code unchanged.
- R6: The trim code saturates at 0 and at 2^TRIM_W-1 and never wraps.
- R7: A count inside the window with `irq_en` at 1 produces a `done_irq` pulse exactly one fast cycle wide. With `irq_en` at 0 there is no pulse.
- R8: The cycle counter saturates at 2^CNT_W-1, so a longer period is compared as that maximum value.
- R9: After reset, `trim_code` is 0 and `done_irq` is 0.
- R10: The trim code and `done_irq` change on the third fast rising edge after the slow-clock rise that forms a reference tick. At the second edge they still hold their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_slow | input | 1 | Slow accurate clock, asynchronous to clk_fast |
| run_en | input | 1 | 1 runs the trim loop, 0 stops it |
| mode_sel | input | 1 | 0 selects continuous operation; 1 keeps the loop halted |
| irq_en | input | 1 | Enables the completion pulse |
| win_lo | input | CNT_W | Lower bound of the target count window |
| win_hi | input | CNT_W | Upper bound of the target count window |
| trim_code | output | TRIM_W | Trim code for the oscillator |
| done_irq | output | 1 | One-cycle pulse when a period lands in the window |

## Verification
Every result depends on a reference tick. The synchronizer, the edge detector and the trim register put the update on the third fast rising edge after the slow-clock rise. The bench therefore drives each slow rise just after a falling fast edge and counts falling edges from there: it expects the old code at the second falling edge, the new code and any pulse at the third, and a pulse-free output at the fourth. The bench counts the fast cycles between the ticks it produces itself, limits that count to the counter maximum, and from it predicts the step or hold the window calls for. This keeps mixed-period transitions exact when the slow period changes.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [1:0] {
    TRIM_IDLE = 2'd0,
    TRIM_ARM  = 2'd1,
    TRIM_MEAS = 2'd2
  } trim_state_e;

endpackage

// File: rtl/osc_trim_edge_sync.sv
module osc_trim_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES:0] shf_q;
  logic [STAGES:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '0;
    end else begin
      shf_q <= shf_d;
    end
  end

  // rising edge seen between the last synchronized stage and its history flop
  assign rise_o = shf_q[STAGES-1] & ~shf_q[STAGES];

endmodule

// File: rtl/osc_trim_refdiv.sv
module osc_trim_refdiv #(
  parameter int DIV_LOG2 = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic tick_o
);

  localparam logic [DIV_LOG2-1:0] DIV_LAST = '1;

  logic [DIV_LOG2-1:0] div_q;
  logic [DIV_LOG2-1:0] div_d;
  logic                div_en;

  always_comb begin
    div_en = edge_i;
    div_d  = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_d;
    end
  end

  assign tick_o = edge_i & (div_q == DIV_LAST);

endmodule

// File: rtl/osc_trim_period_cnt.sv
module osc_trim_period_cnt #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (tick_i) begin
      cnt_d = CNT_ONE;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/osc_trim_stepper.sv
module osc_trim_stepper #(
  parameter int TRIM_W = 7,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [CNT_W-1:0]  meas_i,
  input  logic [CNT_W-1:0]  lo_i,
  input  logic [CNT_W-1:0]  hi_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              hit_o
);

  localparam logic [TRIM_W-1:0] TRIM_TOP = '1;

  logic [TRIM_W-1:0] trim_q;
  logic [TRIM_W-1:0] trim_d;
  logic              trim_en;
  logic              above;
  logic              below;

  always_comb begin
    above   = meas_i > hi_i;
    below   = meas_i < lo_i;
    trim_en = 1'b0;
    trim_d  = trim_q;
    if (upd_i) begin
      if (above) begin
        if (trim_q != '0) begin
          trim_en = 1'b1;
          trim_d  = trim_q - 1'b1;
        end
      end else if (below) begin
        if (trim_q != TRIM_TOP) begin
          trim_en = 1'b1;
          trim_d  = trim_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '0;
    end else if (trim_en) begin
      trim_q <= trim_d;
    end
  end

  assign trim_o = trim_q;
  assign hit_o  = upd_i & ~above & ~below;

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int DIV_LOG2 = 9,
  parameter int CNT_W    = 20,
  parameter int TRIM_W   = 7,
  parameter int SYNC_N   = 2
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              ref_slow,
  input  logic              run_en,
  input  logic              mode_sel,
  input  logic              irq_en,
  input  logic [CNT_W-1:0]  win_lo,
  input  logic [CNT_W-1:0]  win_hi,
  output logic [TRIM_W-1:0] trim_code,
  output logic              done_irq
);

  trim_state_e      st_q;
  trim_state_e      st_d;
  logic             slow_rise;
  logic             ref_tick;
  logic [CNT_W-1:0] meas_cnt;
  logic             active;
  logic             upd;
  logic             hit;
  logic             irq_d;
  logic             irq_q;

  osc_trim_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .async_in (ref_slow),
    .rise_o   (slow_rise)
  );

  osc_trim_refdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk    (clk_fast),
    .rst_n  (rst_n),
    .edge_i (slow_rise),
    .tick_o (ref_tick)
  );

  osc_trim_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk_fast),
    .rst_n  (rst_n),
    .tick_i (ref_tick),
    .cnt_o  (meas_cnt)
  );

  osc_trim_stepper #(.TRIM_W(TRIM_W), .CNT_W(CNT_W)) u_step (
    .clk    (clk_fast),
    .rst_n  (rst_n),
    .upd_i  (upd),
    .meas_i (meas_cnt),
    .lo_i   (win_lo),
    .hi_i   (win_hi),
    .trim_o (trim_code),
    .hit_o  (hit)
  );

  // loop control: continuous mode only, stop takes effect at once
  always_comb begin
    active = run_en & ~mode_sel;
    st_d   = st_q;
    if (!active) begin
      st_d = TRIM_IDLE;
    end else begin
      case (st_q)
        TRIM_IDLE: st_d = TRIM_ARM;
        TRIM_ARM:  if (ref_tick) st_d = TRIM_MEAS;
        TRIM_MEAS: st_d = TRIM_MEAS;
        default:   st_d = TRIM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TRIM_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign upd   = ref_tick & active & (st_q == TRIM_MEAS);
  assign irq_d = hit & irq_en;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign done_irq = irq_q;

endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk #(
  parameter int TRIM_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              mode_sel,
  input logic              irq_en,
  input logic [TRIM_W-1:0] trim,
  input logic              irq
);

  localparam logic [TRIM_W-1:0] TOP = '1;

  // R7: completion pulse never lasts more than one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7: a pulse needs the enable in the cycle before
  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));

  // R1: no pulse unless the loop was active
  p_irq_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run_en && !mode_sel));

  // R1: a stopped loop keeps its trim code
  p_hold_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en && !mode_sel) |-> $stable(trim));

  // R4: a change in the code is a single step
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim) |-> (trim == $past(trim) + 1'b1 || trim == $past(trim) - 1'b1));

  // R6: no wrap at the top of the range
  p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trim) == TOP) |-> (trim != '0));

  // R6: no wrap at the bottom of the range
  p_no_wrap_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trim) == '0) |-> (trim != TOP));

  // R5: a pulse marks an in-window count, which leaves the code unchanged
  p_hit_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $stable(trim));

endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk      (clk_fast),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .mode_sel (mode_sel),
  .irq_en   (irq_en),
  .trim     (trim_code),
  .irq      (done_irq)
);

// File: tb/osc_trim_ctrl_test.sv
module osc_trim_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_LOG2   = 2;
  localparam int CNT_W      = 8;
  localparam int TRIM_W     = 7;
  localparam int TICK_N     = 1 << DIV_LOG2;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int TRIM_MAX   = (1 << TRIM_W) - 1;

  logic              clk_fast = 1'b0;
  logic              rst_n;
  logic              ref_slow;
  logic              run_en;
  logic              mode_sel;
  logic              irq_en;
  logic [CNT_W-1:0]  win_lo;
  logic [CNT_W-1:0]  win_hi;
  logic [TRIM_W-1:0] trim_code;
  logic              done_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int cyc = 0;
  int edges = 0;
  int prev_tick_cyc = 0;
  int m_trim = 0;
  bit m_meas = 0;

  osc_trim_ctrl #(
    .DIV_LOG2 (DIV_LOG2),
    .CNT_W    (CNT_W),
    .TRIM_W   (TRIM_W)
  ) uut (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .ref_slow  (ref_slow),
    .run_en    (run_en),
    .mode_sel  (mode_sel),
    .irq_en    (irq_en),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .trim_code (trim_code),
    .done_irq  (done_irq)
  );

  always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic set_ctrl(input bit run, input bit mode);
    run_en   = run;
    mode_sel = mode;
    if (!(run && !mode)) m_meas = 0;
  endtask

  // one slow period: 4 fast cycles high, n_lo low; slow rise just after a falling fast edge
  task automatic slow_cycle(input int n_lo);
    bit    is_tick;
    bit    running;
    int    old_trim;
    int    p;
    int    irq_exp;
    string tag;
    ref_slow = 1'b1;
    edges++;
    is_tick  = (edges % TICK_N) == 0;
    old_trim = m_trim;
    irq_exp  = 0;
    running  = run_en && !mode_sel;
    tag      = "R2";
    if (is_tick) begin
      p = cyc - prev_tick_cyc;
      prev_tick_cyc = cyc;
      if (!running) begin
        tag = "R1";
      end else if (!m_meas) begin
        m_meas = 1;
        tag = "R3";
      end else begin
        if (p > CNT_MAX) p = CNT_MAX;
        if (p > int'(win_hi)) begin
          if (m_trim > 0) m_trim--; else tag = "R6";
        end else if (p < int'(win_lo)) begin
          if (m_trim < TRIM_MAX) m_trim++; else tag = "R6";
        end else begin
          irq_exp = irq_en ? 1 : 0;
        end
        if (tag == "R2") begin
          if (cyc - (prev_tick_cyc - p) > CNT_MAX && p == CNT_MAX) tag = "R8";
          else if (m_trim != old_trim) tag = "R4";
          else tag = "R5";
        end
      end
    end
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk_fast);
      cyc++;
      if (c == 2) chk("R10 trim before update", int'(trim_code), old_trim);
      if (c == 3) begin
        chk(tag, int'(trim_code), m_trim);
        chk("R7 pulse", int'(done_irq), irq_exp);
      end
      if (c == 4) chk("R7 pulse width", int'(done_irq), 0);
    end
    ref_slow = 1'b0;
    for (int c = 0; c < n_lo; c++) begin
      @(negedge clk_fast);
      cyc++;
    end
  endtask

  task automatic run_ticks(input int n_ticks, input int period);
    for (int k = 0; k < n_ticks * TICK_N; k++) slow_cycle(period - 4);
  endtask

  initial begin
    rst_n    = 1'b0;
    ref_slow = 1'b0;
    run_en   = 1'b0;
    mode_sel = 1'b0;
    irq_en   = 1'b0;
    win_lo   = '0;
    win_hi   = '0;
    repeat (3) @(negedge clk_fast);
    chk("R9 trim after reset", int'(trim_code), 0);
    chk("R9 irq after reset", int'(done_irq), 0);
    rst_n = 1'b1;
    @(negedge clk_fast);
    chk("R9 trim after release", int'(trim_code), 0);

    // R3 / R4: count 32 below window 40..60, code climbs after one arming tick
    win_lo = 8'd40;
    win_hi = 8'd60;
    irq_en = 1'b1;
    set_ctrl(1, 0);
    run_ticks(6, 8);
    chk("R4 climbed to five", int'(trim_code), 5);

    // R5 / R7: count 48 inside window, code held with pulses
    run_ticks(3, 12);
    // R7: pulses suppressed without enable
    irq_en = 1'b0;
    run_ticks(2, 12);
    irq_en = 1'b1;

    // R5: inclusive bounds, count exactly 48 at both edges of the window
    win_lo = 8'd48;
    win_hi = 8'd48;
    run_ticks(2, 12);

    // R8: period 280 saturates at 255, above window 100..200, so code falls
    win_lo = 8'd100;
    win_hi = 8'd200;
    run_ticks(3, 70);

    // R6: count 80 above window 40..60 drives code down to zero and holds
    win_lo = 8'd40;
    win_hi = 8'd60;
    run_ticks(7, 20);
    chk("R6 floor", int'(trim_code), 0);

    // R1: stopped loop, count 32 would raise the code
    set_ctrl(0, 0);
    run_ticks(3, 8);
    chk("R1 held while stopped", int'(trim_code), 0);
    set_ctrl(1, 1);
    run_ticks(3, 8);
    chk("R1 held with mode set", int'(trim_code), 0);

    // R3: restart re-arms, then R6 top saturation with count 32 below window 200..250
    win_lo = 8'd200;
    win_hi = 8'd250;
    set_ctrl(1, 0);
    run_ticks(TRIM_MAX + 6, 8);
    chk("R6 ceiling", int'(trim_code), TRIM_MAX);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_fast);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule